// File: doc/BRIEF.md
# ADC result accumulator and formatter

This block sits behind a 12-bit analog-to-digital converter and turns its stream of unsigned samples into a 16-bit result word, presented as a high byte and a low byte. Each sample arrives with a one-cycle valid strobe. A two-bit repeat selector picks how many samples make one result: 1, 4, 8 or 16.

With a repeat of one, every sample becomes a result on its own. It is placed at the bottom of the word (right-justified) or at the top (left-justified), as the justification input asks. With a repeat of 4, 8 or 16, consecutive samples are summed in a 16-bit accumulator. The sum is published right-justified only when the last sample of the set arrives. Between publications the result word holds its last value. A one-cycle ready pulse marks every update. Changing either setting abandons the set in progress, so the next set starts from an empty sum.

Top module: `adc_acc_fmt`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `res_hi`/`res_lo` read 0x0000 and `res_rdy` is 0.
- R2: With `rpt_sel` = 2'b00 (one sample per result) and `left_just` = 0, a sample S taken on a clock edge appears as {4'h0, S} on the result one clock later, with `res_rdy` high in that same cycle.
- R3: With `rpt_sel` = 2'b00 and `left_just` = 1, a sample S appears as {S, 4'h0} one clock later, with `res_rdy` high in that same cycle.
- R4: With `rpt_sel` = 2'b01, 2'b10 or 2'b11 (4, 8 or 16 samples per result), the result becomes the unsigned sum of the set's samples, zero-extended to 16 bits, one clock after the last sample of the set, with `res_rdy` high in that cycle.
- R5: While a set is incomplete, the result word holds its previous value and `res_rdy` stays low.
- R6: When the repeat count is greater than one, `left_just` has no effect and the sum is right-justified.
- R7: A change in `rpt_sel` or `left_just` discards any partial sum and sample count. A sample taken in the same cycle as the change counts as the first sample of a new set.
- R8: Sixteen samples of 0xFFF give 0xFFF0 and four give 0x3FFC, with no overflow or wrap.
- R9: `res_rdy` is high for one cycle only, and only in the cycle after a valid sample was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_data | input | 12 | Unsigned converter code |
| rpt_sel | input | 2 | Samples per result: 00=1, 01=4, 10=8, 11=16 |
| left_just | input | 1 | 1 = left-justify single-sample results |
| res_hi | output | 8 | Result bits 15:8 |
| res_lo | output | 8 | Result bits 7:0 |
| res_rdy | output | 1 | One-cycle pulse when the result updates |

## Verification
Single-sample mode is driven with full-scale, mid-scale and just-below-mid codes under both justifications. These codes show whether the sample lands in the right bit field and whether the unused bits are zero. Every accumulating count is driven with sets of equal full-scale samples, which show the sum is not wrapped, and with a set of unequal samples, which shows the block truly adds rather than shifting one sample. The intermediate cycles of each set are checked for a held result and no pulse. One scenario breaks off a partial set by toggling the justification bit. This shows both that the stale sum is dropped and that the bit is ignored for accumulated results.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;

  localparam int SMP_W = 12;
  localparam int ACC_W = 16;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    RPT_1  = 2'b00,
    RPT_4  = 2'b01,
    RPT_8  = 2'b10,
    RPT_16 = 2'b11
  } rpt_e;

  // index of the final sample of a set, counting from zero
  function automatic logic [CNT_W-1:0] last_idx(input rpt_e r);
    case (r)
      RPT_4:   last_idx = CNT_W'(3);
      RPT_8:   last_idx = CNT_W'(7);
      RPT_16:  last_idx = CNT_W'(15);
      default: last_idx = '0;
    endcase
  endfunction

endpackage

// File: rtl/adc_cfg_watch.sv
module adc_cfg_watch
  import adc_acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  rpt_e rpt,
  input  logic lj,
  output logic chg
);

  localparam int CFG_W = 3;

  logic [CFG_W-1:0] cur_cfg;
  logic [CFG_W-1:0] prev_q;
  logic [CFG_W-1:0] prev_d;

  assign cur_cfg = {rpt, lj};

  always_comb begin
    prev_d = cur_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign chg = (cur_cfg != prev_q);

endmodule

// File: rtl/adc_sum_core.sv
module adc_sum_core
  import adc_acc_pkg::*;
#(
  parameter int DW = SMP_W,
  parameter int AW = ACC_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] data,
  input  logic          chg,
  input  rpt_e          rpt,
  output logic          done,
  output logic [AW-1:0] sum
);

  localparam int PAD_W = AW - DW;

  logic [AW-1:0] acc_q, acc_d, base_acc;
  logic [CW-1:0] cnt_q, cnt_d, base_cnt;
  logic          acc_en;

  // a settings change restarts the set, counting the current sample as its first
  assign base_acc = chg ? '0 : acc_q;
  assign base_cnt = chg ? '0 : cnt_q;

  assign sum  = base_acc + {{PAD_W{1'b0}}, data};
  assign done = vld && (base_cnt == CW'(last_idx(rpt)));

  always_comb begin
    acc_en = vld || chg;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    if (vld) begin
      if (done) begin
        acc_d = '0;
        cnt_d = '0;
      end else begin
        acc_d = sum;
        cnt_d = base_cnt + CW'(1);
      end
    end else if (chg) begin
      acc_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt
  import adc_acc_pkg::*;
#(
  parameter int DW = SMP_W,
  parameter int AW = ACC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [AW-1:0] sum,
  input  rpt_e          rpt,
  input  logic          lj,
  output logic [AW-1:0] res,
  output logic          rdy
);

  localparam int LPAD = AW - DW;

  logic [AW-1:0] res_q, res_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    res_d = res_q;
    rdy_d = done;
    if (done) begin
      if (rpt == RPT_1 && lj) res_d = {sum[DW-1:0], {LPAD{1'b0}}};
      else                    res_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      if (done) res_q <= res_d;
    end
  end

  assign res = res_q;
  assign rdy = rdy_q;

endmodule

// File: rtl/adc_acc_fmt.sv
module adc_acc_fmt
  import adc_acc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic [11:0] smp_data,
  input  logic [1:0]  rpt_sel,
  input  logic        left_just,
  output logic [7:0]  res_hi,
  output logic [7:0]  res_lo,
  output logic        res_rdy
);

  rpt_e             rpt;
  logic             chg;
  logic             done;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] res;

  assign rpt = rpt_e'(rpt_sel);

  adc_cfg_watch u_watch (
    .clk   (clk),
    .rst_n (rst_n),
    .rpt   (rpt),
    .lj    (left_just),
    .chg   (chg)
  );

  adc_sum_core #(.DW(SMP_W), .AW(ACC_W), .CW(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (smp_vld),
    .data  (smp_data),
    .chg   (chg),
    .rpt   (rpt),
    .done  (done),
    .sum   (sum)
  );

  adc_res_fmt #(.DW(SMP_W), .AW(ACC_W)) u_fmt (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done),
    .sum   (sum),
    .rpt   (rpt),
    .lj    (left_just),
    .res   (res),
    .rdy   (res_rdy)
  );

  assign res_hi = res[15:8];
  assign res_lo = res[7:0];

endmodule

// File: rtl/adc_acc_fmt_chk.sv
module adc_acc_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_vld,
  input logic [11:0] smp_data,
  input logic [1:0]  rpt_sel,
  input logic        left_just,
  input logic [7:0]  res_hi,
  input logic [7:0]  res_lo,
  input logic        res_rdy
);

  logic [15:0] res_w;
  assign res_w = {res_hi, res_lo};

  // R9
  a_r9_rdy_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    res_rdy |-> $past(smp_vld));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_rdy |-> $stable(res_w));

  // R2
  a_r2_right_single: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && rpt_sel == 2'b00 && !left_just) |=> (res_rdy && res_w == {4'h0, $past(smp_data)}));

  // R3
  a_r3_left_single: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && rpt_sel == 2'b00 && left_just) |=> (res_rdy && res_w == {$past(smp_data), 4'h0}));

  // R6, R8: a four-sample sum never reaches bit 14
  a_r6_four_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rdy && $past(rpt_sel) == 2'b01) |-> (res_w[15:14] == 2'b00));

endmodule

bind adc_acc_fmt adc_acc_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .smp_data  (smp_data),
  .rpt_sel   (rpt_sel),
  .left_just (left_just),
  .res_hi    (res_hi),
  .res_lo    (res_lo),
  .res_rdy   (res_rdy)
);

// File: tb/tb_adc_acc_fmt.sv
module tb_adc_acc_fmt;

  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [11:0] smp_data;
  logic [1:0]  rpt_sel;
  logic        left_just;
  logic [7:0]  res_hi;
  logic [7:0]  res_lo;
  logic        res_rdy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  adc_acc_fmt dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .rpt_sel(rpt_sel), .left_just(left_just),
    .res_hi(res_hi), .res_lo(res_lo), .res_rdy(res_rdy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual rdy/res=%h expected %h", req, act, exp);
    end
  endtask

  // drive one sample for one cycle; returns at the next falling edge
  task automatic send(input logic [11:0] s);
    smp_vld  = 1'b1;
    smp_data = s;
    @(negedge clk);
    smp_vld  = 1'b0;
    smp_data = '0;
  endtask

  task automatic set_cfg(input logic [1:0] r, input logic lj);
    rpt_sel   = r;
    left_just = lj;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; rpt_sel = 2'b00; left_just = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", {res_rdy, res_hi, res_lo}, 17'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {res_rdy, res_hi, res_lo}, 17'h0);
  endtask

  task automatic t_single(input logic lj);
    logic [11:0] codes [3] = '{12'hFFF, 12'h800, 12'h7FF};
    set_cfg(2'b00, lj);
    foreach (codes[i]) begin
      send(codes[i]);
      if (lj) check("R3 left single", {res_rdy, res_hi, res_lo}, {1'b1, codes[i], 4'h0});
      else    check("R2 right single", {res_rdy, res_hi, res_lo}, {1'b1, 4'h0, codes[i]});
      @(negedge clk);
      check("R9 pulse one cycle", {16'h0, res_rdy}, 17'h0);
    end
  endtask

  // set of n equal samples; previous result must hold until the last one
  task automatic t_set(input logic [1:0] r, input int n, input logic [11:0] s, input logic lj);
    logic [15:0] held;
    logic [15:0] exp;
    set_cfg(r, lj);
    held = {res_hi, res_lo};
    exp  = 16'(n) * {4'h0, s};
    for (int k = 0; k < n - 1; k++) begin
      send(s);
      check("R5 hold during set", {res_rdy, res_hi, res_lo}, {1'b0, held});
    end
    send(s);
    check("R4 R8 set sum", {res_rdy, res_hi, res_lo}, {1'b1, exp});
    @(negedge clk);
    check("R9 pulse one cycle", {16'h0, res_rdy}, 17'h0);
  endtask

  task automatic t_mixed8();
    logic [15:0] exp;
    set_cfg(2'b10, 1'b0);
    exp = 0;
    for (int k = 0; k < 8; k++) begin
      send(12'(k * 300 + 5));
      exp += 16'(k * 300 + 5);
    end
    check("R4 unequal samples", {res_rdy, res_hi, res_lo}, {1'b1, exp});
  endtask

  task automatic t_abort();
    set_cfg(2'b01, 1'b0);
    send(12'h100);
    send(12'h100);
    left_just = 1'b1;
    for (int k = 0; k < 3; k++) begin
      send(12'h001);
      check("R7 no early publish", {16'h0, res_rdy}, 17'h0);
    end
    send(12'h001);
    check("R7 R6 fresh set right-justified", {res_rdy, res_hi, res_lo}, 17'h1_0004);
    // change coinciding with a sample: that sample opens the new set
    send(12'h010);
    rpt_sel = 2'b00; left_just = 1'b0;
    send(12'h020);
    check("R7 change with sample", {res_rdy, res_hi, res_lo}, 17'h1_0020);
    rpt_sel = 2'b01;
    send(12'h002);
    send(12'h002);
    send(12'h002);
    send(12'h002);
    check("R7 new set after change", {res_rdy, res_hi, res_lo}, 17'h1_0008);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_single(1'b0);
    t_single(1'b1);
    t_set(2'b01, 4, 12'hFFF, 1'b0);
    t_set(2'b10, 8, 12'hFFF, 1'b0);
    t_set(2'b11, 16, 12'hFFF, 1'b0);
    t_set(2'b11, 16, 12'h800, 1'b1);
    t_set(2'b01, 4, 12'h7FF, 1'b1);
    t_set(2'b10, 8, 12'h000, 1'b0);
    t_mixed8();
    t_abort();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule